// File: doc/BRIEF.md
# Eight-bit universal shift register with shared data bus

This block is a storage and shift register, eight stages wide by default. Two mode bits pick one of four operations, each applied on the rising clock edge: keep the contents, move them one place toward the low end, move them one place toward the high end, or capture a full word in parallel. The parallel data lines form a shared bidirectional bus. The block drives the bus to show its contents. In the capture mode it releases the bus and samples it. The bus is split into `bus_in`, `bus_out` and the drive flag `bus_oe`, so that the pad logic outside the block can build the tri-state pins.

Each end of the register has a serial input and a cascade output. The cascade outputs are always valid, so several blocks can be chained in either direction while their buses stay released. An active-low clear empties the register at once, with no clock needed.

Top module: `ushift_reg`

## Requirements
- R1: While `rst_n` is low, every stage reads 0 at once, without waiting for a clock. The clear wins over every mode.
- R2: With `mode_sel` = 2'b00 (hold), a rising edge leaves the contents unchanged.
- R3: With `mode_sel` = 2'b10 (shift toward high index), a rising edge moves `ser_right_in` into bit 0 and bit i-1 into bit i.
- R4: With `mode_sel` = 2'b01 (shift toward low index), a rising edge moves `ser_left_in` into bit WIDTH-1 and bit i+1 into bit i.
- R5: With `mode_sel` = 2'b11 (capture), a rising edge copies `bus_in` into the register.
- R6: `bus_oe` is high in the same cycle exactly when `en_a_n` and `en_b_n` are both low and `mode_sel` is not 2'b11. In capture mode it is low whatever the enables are.
- R7: `bus_out` carries the register contents, bit i holding stage i.
- R8: Shifting goes on normally while the bus is released. The contents reached during that time show on `bus_out` once both enables are low again.
- R9: `cas_left` always equals stage 0 and `cas_right` always equals stage WIDTH-1, whatever the enables are.
- R10: Two blocks chain in both directions when `cas_right` of the first feeds `ser_right_in` of the second and `cas_left` of the second feeds `ser_left_in` of the first. The word then moves across the pair one stage per edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| mode_sel | input | 2 | 00 hold, 01 shift to low index, 10 shift to high index, 11 capture |
| en_a_n | input | 1 | Active-low bus enable, first of two |
| en_b_n | input | 1 | Active-low bus enable, second of two |
| ser_right_in | input | 1 | Serial bit entering stage 0 on a shift toward high index |
| ser_left_in | input | 1 | Serial bit entering stage WIDTH-1 on a shift toward low index |
| bus_in | input | WIDTH | Value sampled from the shared bus |
| bus_out | output | WIDTH | Value offered to the shared bus |
| bus_oe | output | 1 | High when the bus pins should be driven |
| cas_left | output | 1 | Stage 0, never gated |
| cas_right | output | 1 | Stage WIDTH-1, never gated |

## Verification
Register results (R2 to R5, R8, R10) appear one rising edge after their inputs. The bench applies the inputs on a falling edge and compares against its own model at the next falling edge. `bus_oe` and the cascade outputs are combinational from the mode, the enables and the stages. The bench therefore checks them a fraction of a nanosecond after a change, inside the same half period, before any rising edge. The clear is checked the same way: shortly after `rst_n` falls between edges, and again after a rising edge that arrives while the clear is still held.

// File: rtl/ushift_pkg.sv
package ushift_pkg;
   typedef enum logic [1:0] {
      M_HOLD  = 2'b00,
      M_TOLOW = 2'b01,
      M_TOHI  = 2'b10,
      M_LOAD  = 2'b11
   } mode_e;
endpackage

// File: rtl/ushift_ctrl.sv
module ushift_ctrl
   import ushift_pkg::*;
(
   input  logic [1:0] mode_sel,
   input  logic       en_a_n,
   input  logic       en_b_n,
   output mode_e      mode,
   output logic       drive
);
   always_comb begin
      mode  = mode_e'(mode_sel);
      // the bus is released during capture so that it can be sampled
      drive = !en_a_n && !en_b_n && (mode != M_LOAD);
   end
endmodule

// File: rtl/ushift_cell.sv
module ushift_cell
   import ushift_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  mode_e mode,
   input  logic  from_low,
   input  logic  from_high,
   input  logic  par_in,
   output logic  q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else begin
         case (mode)
            M_HOLD:  q <= q;
            M_TOLOW: q <= from_high;
            M_TOHI:  q <= from_low;
            default: q <= par_in;
         endcase
      end
   end
endmodule

// File: rtl/ushift_reg.sv
module ushift_reg
   import ushift_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode_sel,
   input  logic             en_a_n,
   input  logic             en_b_n,
   input  logic             ser_right_in,
   input  logic             ser_left_in,
   input  logic [WIDTH-1:0] bus_in,
   output logic [WIDTH-1:0] bus_out,
   output logic             bus_oe,
   output logic             cas_left,
   output logic             cas_right
);
   localparam int TOP = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("ushift_reg: WIDTH must be at least 2");
      end
   endgenerate

   mode_e            mode;
   logic [WIDTH-1:0] stage;

   ushift_ctrl u_ctrl (
      .mode_sel (mode_sel),
      .en_a_n   (en_a_n),
      .en_b_n   (en_b_n),
      .mode     (mode),
      .drive    (bus_oe)
   );

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_stage
         logic lo_src;
         logic hi_src;
         if (i == 0) begin : g_lo_end
            assign lo_src = ser_right_in;
         end else begin : g_lo_mid
            assign lo_src = stage[i-1];
         end
         if (i == TOP) begin : g_hi_end
            assign hi_src = ser_left_in;
         end else begin : g_hi_mid
            assign hi_src = stage[i+1];
         end
         ushift_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode      (mode),
            .from_low  (lo_src),
            .from_high (hi_src),
            .par_in    (bus_in[i]),
            .q         (stage[i])
         );
      end
   endgenerate

   assign bus_out   = stage;
   assign cas_left  = stage[0];
   assign cas_right = stage[TOP];
endmodule

// File: rtl/ushift_reg_chk.sv
module ushift_reg_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       mode_sel,
   input logic             en_a_n,
   input logic             en_b_n,
   input logic             ser_right_in,
   input logic             ser_left_in,
   input logic [WIDTH-1:0] bus_in,
   input logic [WIDTH-1:0] bus_out,
   input logic             bus_oe,
   input logic             cas_left,
   input logic             cas_right
);
   always @(posedge clk) begin
      if (!rst_n) begin
         p_clear_r1: assert (bus_out == '0 && !cas_left && !cas_right);
      end
   end

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mode_sel == 2'b00 |=> $stable(bus_out));

   p_tohi_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mode_sel == 2'b10 |=> (bus_out[0] == $past(ser_right_in)) &&
                            (bus_out[WIDTH-1:1] == $past(bus_out[WIDTH-2:0])));

   p_tolow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mode_sel == 2'b01 |=> (bus_out[WIDTH-1] == $past(ser_left_in)) &&
                            (bus_out[WIDTH-2:0] == $past(bus_out[WIDTH-1:1])));

   p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mode_sel == 2'b11 |=> bus_out == $past(bus_in));

   p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mode_sel == 2'b11 |-> !bus_oe);

   p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_oe && mode_sel != 2'b11) |-> (en_a_n || en_b_n));

   p_cas_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((en_a_n || en_b_n) && mode_sel == 2'b10) |=> cas_right == $past(bus_out[WIDTH-2]));

   p_cas_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((en_a_n || en_b_n) && mode_sel == 2'b01) |=> cas_left == $past(bus_out[1]));
endmodule

bind ushift_reg ushift_reg_chk #(.WIDTH(WIDTH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mode_sel     (mode_sel),
   .en_a_n       (en_a_n),
   .en_b_n       (en_b_n),
   .ser_right_in (ser_right_in),
   .ser_left_in  (ser_left_in),
   .bus_in       (bus_in),
   .bus_out      (bus_out),
   .bus_oe       (bus_oe),
   .cas_left     (cas_left),
   .cas_right    (cas_right)
);

// File: tb/ushift_reg_bench.sv
`timescale 1ns/1ps
module ushift_reg_bench;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [1:0]   mode_sel = 2'b00;
   logic         en_a_n = 1'b0, en_b_n = 1'b0;
   logic         tb_sr = 1'b0, tb_sl = 1'b0, p_sl = 1'b0;
   logic         chain = 1'b0;
   logic [W-1:0] bus_in = '0, p_bus_in = '0;
   logic [W-1:0] bus_out, p_bus_out;
   logic         bus_oe, p_bus_oe, cas_l, cas_r, p_cas_l, p_cas_r;
   logic         main_sl;
   logic [W-1:0] exp_m = '0, exp_p = '0;
   int           checks = 0, failures = 0;
   bit           finished = 1'b0;

   always #2 clk = ~clk;
   assign main_sl = chain ? p_cas_l : tb_sl;

   ushift_reg #(.WIDTH(W)) u_ushift_reg (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .en_a_n(en_a_n), .en_b_n(en_b_n),
      .ser_right_in(tb_sr), .ser_left_in(main_sl), .bus_in(bus_in),
      .bus_out(bus_out), .bus_oe(bus_oe), .cas_left(cas_l), .cas_right(cas_r));

   ushift_reg #(.WIDTH(W)) u_peer (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .en_a_n(en_a_n), .en_b_n(en_b_n),
      .ser_right_in(cas_r), .ser_left_in(p_sl), .bus_in(p_bus_in),
      .bus_out(p_bus_out), .bus_oe(p_bus_oe), .cas_left(p_cas_l), .cas_right(p_cas_r));

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] model(input logic [W-1:0] q, input logic [1:0] m,
                                          input logic r, input logic l, input logic [W-1:0] d);
      case (m)
         2'b00:   return q;
         2'b01:   return {l, q[W-1:1]};
         2'b10:   return {q[W-2:0], r};
         default: return d;
      endcase
   endfunction

   // called at a falling edge; the result is checked at the next falling edge
   task automatic step(input logic [1:0] m, input logic r, input logic l, input logic [W-1:0] d,
                       input logic [W-1:0] pd, input string req);
      logic [W-1:0] nm, np;
      mode_sel = m; tb_sr = r; tb_sl = l;
      bus_in = (m == 2'b11) ? d : '0;
      p_bus_in = (m == 2'b11) ? pd : '0;
      nm = model(exp_m, m, r, chain ? exp_p[0] : l, d);
      np = model(exp_p, m, exp_m[W-1], p_sl, pd);
      @(negedge clk);
      exp_m = nm; exp_p = np;
      if (en_a_n == 1'b0 && en_b_n == 1'b0) check(req, bus_out, exp_m);
      check({req, " cascade R9"}, {6'd0, cas_r, cas_l}, {6'd0, exp_m[W-1], exp_m[0]});
   endtask

   task automatic t_reset();
      check("R1 reset contents", bus_out, '0);
      check("R6 oe after reset", {7'd0, bus_oe}, 8'd1);
      check("R9 cascades after reset", {6'd0, cas_r, cas_l}, '0);
   endtask

   task automatic t_load_hold();
      step(2'b11, 0, 0, 8'hA5, 8'h3C, "R5 load A5");
      step(2'b00, 1, 1, 8'h00, 8'h00, "R2 hold");
      step(2'b00, 0, 1, 8'h00, 8'h00, "R2 hold again");
      step(2'b11, 0, 0, 8'h5A, 8'h00, "R5 load 5A");
      check("R7 bus_out shows contents", bus_out, 8'h5A);
   endtask

   task automatic t_shifts();
      step(2'b11, 0, 0, 8'h81, 8'h00, "R5 load 81");
      step(2'b10, 1, 0, 8'h00, 8'h00, "R3 shift hi in 1");
      step(2'b10, 0, 0, 8'h00, 8'h00, "R3 shift hi in 0");
      step(2'b10, 1, 0, 8'h00, 8'h00, "R3 shift hi in 1");
      step(2'b01, 0, 1, 8'h00, 8'h00, "R4 shift lo in 1");
      step(2'b01, 0, 0, 8'h00, 8'h00, "R4 shift lo in 0");
      step(2'b01, 0, 1, 8'h00, 8'h00, "R4 shift lo in 1");
   endtask

   task automatic t_enables();
      for (int m = 0; m < 4; m++) begin
         for (int e = 0; e < 4; e++) begin
            mode_sel = m[1:0]; en_a_n = e[0]; en_b_n = e[1];
            #0.1;
            check($sformatf("R6 oe mode=%0d en=%0d", m, e), {7'd0, bus_oe},
                  {7'd0, (e == 0) && (m != 3)});
         end
      end
      mode_sel = 2'b00; en_a_n = 1'b0; en_b_n = 1'b0;
      @(negedge clk);
      check("R2 enables sweep left contents", bus_out, exp_m);
   endtask

   task automatic t_hidden();
      step(2'b11, 0, 0, 8'hC3, 8'h00, "R5 load C3");
      en_a_n = 1'b1;
      for (int k = 0; k < 3; k++) step(2'b10, k[0], 0, 0, 0, "R8 hidden shift hi");
      en_a_n = 1'b0; en_b_n = 1'b1;
      for (int k = 0; k < 2; k++) step(2'b01, 0, 1, 0, 0, "R8 hidden shift lo");
      check("R8 oe low while hidden", {7'd0, bus_oe}, '0);
      en_b_n = 1'b0;
      step(2'b00, 0, 0, 0, 0, "R8 contents after re-enable");
   endtask

   task automatic t_clear();
      step(2'b11, 0, 0, 8'hFF, 8'hFF, "R5 load FF");
      mode_sel = 2'b10; tb_sr = 1'b1;
      #0.5 rst_n = 1'b0;
      #0.3 check("R1 async clear", bus_out, '0);
      check("R1 async clear peer", p_bus_out, '0);
      @(negedge clk);
      check("R1 clear beats shift", bus_out, '0);
      mode_sel = 2'b00; rst_n = 1'b1;
      exp_m = '0; exp_p = '0;
      @(negedge clk);
      check("R1 stays clear after release", bus_out, '0);
   endtask

   task automatic t_chain();
      chain = 1'b1; p_sl = 1'b0;
      step(2'b11, 0, 0, 8'hB4, 8'h3C, "R10 load pair");
      for (int k = 0; k < W; k++) step(2'b10, k[0], 0, 0, 0, "R10 chain hi main");
      check("R10 peer got main word", p_bus_out, 8'hB4);
      check("R10 peer model", p_bus_out, exp_p);
      p_sl = 1'b1;
      for (int k = 0; k < W; k++) step(2'b01, 0, 0, 0, 0, "R10 chain lo main");
      check("R10 main got peer word back", bus_out, 8'hB4);
      check("R10 peer filled from its serial in", p_bus_out, 8'hFF);
      chain = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_load_hold();
      t_shifts();
      t_enables();
      t_hidden();
      t_clear();
      t_chain();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++; failures++;
         $display("FAIL watchdog actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule